// File: doc/BRIEF.md
# 16-bit ALU with Registered Status Flags

This block is the arithmetic and logic unit of a small 16-bit processor. It takes two operands, a five-bit operation code, a carry input and a flag-write enable. It returns the computed result, a strobe that says whether the result should be written back, and four status flags: sign, zero, carry and overflow. The result path is purely combinational. The flags sit in a register that updates on the clock edge.

The operation code has two fields. Bits [4:1] select the function. Bit 0 is the shift count, which is one position when clear and two when set; non-shift functions ignore it. There is no separate subtractor. Subtract, compare and negate all run through one adder that adds the two's complement of the subtrahend. Carry and overflow are taken from the full 17-bit sum. Sign and zero are taken from the 16-bit truncated result. Each function updates its own subset of flags, and the rest keep their value.

Top module: `alu16_core`

## Requirements
- R1: A synchronous active-high reset clears all four flags to 0.
- R2: Function 0 (add) returns a+b and function 1 (add with carry) returns a+b+carry_in. Both write the result. Carry is bit 16 of the unmasked sum, and overflow is set when the two addends share a sign that the 16-bit result does not.
- R3: Function 2 (subtract) returns a-b, computed as a + ~b + 1, and writes the result. Carry is 1 exactly when a >= b unsigned. Overflow is set when the signed difference falls outside -32768..32767.
- R4: Function 3 (compare) sets sign, zero, carry and overflow exactly as subtract would, and holds result_we_o low.
- R5: Function 4 (negate) returns 0-a and writes the result. Carry is 1 only for a=0, and overflow is 1 only for a=0x8000.
- R6: For every function below 14, the sign flag takes bit 15 of the 16-bit result and the zero flag is set when all 16 result bits are 0.
- R7: Function 5 (complement, ~a), function 6 (a AND b) and function 7 (a XOR b) write the result and update only sign and zero. Carry and overflow keep their values.
- R8: Op bit 0 selects a shift of one position (0) or two positions (1). Function 8 (left shift, zero fill) truncates to 16 bits. Function 10 (logical right) and function 11 (arithmetic right) also shift as named. All three write the result and update only sign and zero.
- R9: Function 9 (left shift into carry) returns the same result as function 8. Carry takes original bit 15. For a two-position shift, overflow takes original bit 14; for a one-position shift, overflow is unchanged.
- R10: Function 12 (rotate left through carry) returns {a[14:0],carry_in} for one position, or {a[13:0],carry_in,V} for two, where V is the current overflow flag. Carry takes a[15], and on two positions overflow takes a[14]. Function 13 (rotate right through carry) returns {carry_in,a[15:1]} or {V,carry_in,a[15:2]}. Carry takes a[0], and on two positions overflow takes a[1].
- R11: The flags change only on a clock edge where flag_we_i is high. Otherwise they hold.
- R12: Functions 14 and 15 are reserved. They hold result_we_o low and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Function in [4:1], shift count in [0] |
| a_i | input | 16 | First operand (sole operand for unary functions) |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry input for add-with-carry and rotates |
| flag_we_i | input | 1 | Enables the flag update on this edge |
| result_o | output | 16 | Combinational result |
| result_we_o | output | 1 | Result write-back strobe |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The assertions assume that op_i, a_i, carry_i and flag_we_i are stable and known around each rising edge. They also assume that reset is held for at least one edge before the first operation, so that a past-cycle comparison never reaches back to undriven values. The bench changes every input only on the falling edge. It holds reset for three edges. It then sweeps all 32 operation codes against a grid of boundary operands (0, 1, 0x7FFF, 0x8000, 0xFFFF and alternating patterns) with both carry-in values, followed by random vectors. The flag-write enable is randomised throughout, so both the hold case and the update case occur for every function.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

    localparam int ALU_W  = 16;
    localparam int OP_W   = 5;
    localparam int FN_W   = OP_W - 1;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 4'd0,
        FN_ADC  = 4'd1,
        FN_SUB  = 4'd2,
        FN_CMP  = 4'd3,
        FN_NEG  = 4'd4,
        FN_COM  = 4'd5,
        FN_AND  = 4'd6,
        FN_XOR  = 4'd7,
        FN_SLL  = 4'd8,
        FN_SLLC = 4'd9,
        FN_SLR  = 4'd10,
        FN_SAR  = 4'd11,
        FN_RLC  = 4'd12,
        FN_RRC  = 4'd13,
        FN_RSV0 = 4'd14,
        FN_RSV1 = 4'd15
    } alu_fn_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic alu_fn_e fn_of(input logic [OP_W-1:0] op);
        return alu_fn_e'(op[OP_W-1:1]);
    endfunction

    function automatic logic is_reserved(input alu_fn_e fn);
        return (fn == FN_RSV0) || (fn == FN_RSV1);
    endfunction

endpackage

// File: rtl/alu16_adder.sv
`timescale 1ns/1ps
module alu16_adder
    import alu16_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           vout
);
    localparam int WW = W + 1;

    logic [W-1:0]  x, y;
    logic          ci;
    logic [WW-1:0] wide;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        unique case (fn)
            FN_ADC:         ci = cin;
            FN_SUB, FN_CMP: begin y = ~b; ci = 1'b1; end
            FN_NEG:         begin x = '0; y = ~a; ci = 1'b1; end
            default:        ;
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign vout = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);

endmodule

// File: rtl/alu16_logic.sv
`timescale 1ns/1ps
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    always_comb begin
        unique case (fn)
            FN_COM:  res = ~a;
            FN_AND:  res = a & b;
            FN_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu16_shifter.sv
`timescale 1ns/1ps
module alu16_shifter
    import alu16_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_fn_e        fn,
    input  logic           dbl,
    input  logic [W-1:0]   a,
    input  logic           cin,
    input  logic           vin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           vout
);
    logic [W-1:0] shl, shr, sar;

    assign shl = dbl ? (a << 2) : (a << 1);
    assign shr = dbl ? (a >> 2) : (a >> 1);
    assign sar = dbl ? W'($signed(a) >>> 2) : W'($signed(a) >>> 1);

    always_comb begin
        res  = a;
        cout = 1'b0;
        vout = 1'b0;
        unique case (fn)
            FN_SLL:  res = shl;
            FN_SLLC: begin
                res  = shl;
                cout = a[W-1];
                vout = a[W-2];
            end
            FN_SLR:  res = shr;
            FN_SAR:  res = sar;
            FN_RLC:  begin
                res  = dbl ? {a[W-3:0], cin, vin} : {a[W-2:0], cin};
                cout = a[W-1];
                vout = a[W-2];
            end
            FN_RRC:  begin
                res  = dbl ? {vin, cin, a[W-1:2]} : {cin, a[W-1:1]};
                cout = a[0];
                vout = a[1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            carry_i,
    input  logic            flag_we_i,
    output logic [W-1:0]    result_o,
    output logic            result_we_o,
    output logic            flag_s_o,
    output logic            flag_z_o,
    output logic            flag_c_o,
    output logic            flag_v_o
);
    alu_fn_e     fn;
    logic        dbl;
    alu_flags_t  flags_q, flags_n, upd;
    logic [W-1:0] add_sum, log_res, sh_res, res;
    logic        add_c, add_v, sh_c, sh_v;

    assign fn  = fn_of(op_i);
    assign dbl = op_i[0];

    alu16_adder #(.W(W)) u_add (
        .fn(fn), .a(a_i), .b(b_i), .cin(carry_i),
        .sum(add_sum), .cout(add_c), .vout(add_v)
    );

    alu16_logic #(.W(W)) u_log (
        .fn(fn), .a(a_i), .b(b_i), .res(log_res)
    );

    alu16_shifter #(.W(W)) u_sh (
        .fn(fn), .dbl(dbl), .a(a_i), .cin(carry_i), .vin(flags_q.v),
        .res(sh_res), .cout(sh_c), .vout(sh_v)
    );

    always_comb begin
        res         = a_i;
        result_we_o = 1'b1;
        upd         = '{s: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
        flags_n.c   = flags_q.c;
        flags_n.v   = flags_q.v;
        unique case (fn)
            FN_ADD, FN_ADC, FN_SUB, FN_NEG: begin
                res       = add_sum;
                upd.c     = 1'b1;
                upd.v     = 1'b1;
                flags_n.c = add_c;
                flags_n.v = add_v;
            end
            FN_CMP: begin
                res         = add_sum;
                result_we_o = 1'b0;
                upd.c       = 1'b1;
                upd.v       = 1'b1;
                flags_n.c   = add_c;
                flags_n.v   = add_v;
            end
            FN_COM, FN_AND, FN_XOR: res = log_res;
            FN_SLL, FN_SLR, FN_SAR: res = sh_res;
            FN_SLLC, FN_RLC, FN_RRC: begin
                res       = sh_res;
                upd.c     = 1'b1;
                upd.v     = dbl;
                flags_n.c = sh_c;
                flags_n.v = sh_v;
            end
            default: begin
                result_we_o = 1'b0;
                upd         = '0;
            end
        endcase
        flags_n.s = res[W-1];
        flags_n.z = (res == '0);
    end

    assign result_o = res;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (flag_we_i) begin
            if (upd.s) flags_q.s <= flags_n.s;
            if (upd.z) flags_q.z <= flags_n.z;
            if (upd.c) flags_q.c <= flags_n.c;
            if (upd.v) flags_q.v <= flags_n.v;
        end
    end

    assign flag_s_o = flags_q.s;
    assign flag_z_o = flags_q.z;
    assign flag_c_o = flags_q.c;
    assign flag_v_o = flags_q.v;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags_q == '0));

    // R11
    a_r11_hold_without_we: assert property (@(posedge clk) disable iff (rst)
        !flag_we_i |=> $stable(flags_q));

    // R12
    a_r12_reserved_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        is_reserved(fn) |=> $stable(flags_q));

    a_r12_reserved_no_write: assert property (@(posedge clk) disable iff (rst)
        is_reserved(fn) |-> !result_we_o);

    // R4
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_CMP) |-> !result_we_o);

    // R6
    a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && !is_reserved(fn)) |=> (flag_z_o == ($past(result_o) == '0)));

    // R5
    a_r5_neg_min_overflow: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && fn == FN_NEG && a_i == {1'b1, {(W-1){1'b0}}}) |=> flag_v_o);

endmodule

// File: tb/tb_alu16_core.sv
`timescale 1ns/1ps
module tb_alu16_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op;
    logic [15:0] a, b;
    logic        cin, fwe;
    logic [15:0] result;
    logic        result_we;
    logic        fs, fz, fc, fv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0] exp_flags;  // {s,z,c,v}

    always #5 clk = ~clk;

    alu16_core dut (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
        .carry_i(cin), .flag_we_i(fwe), .result_o(result),
        .result_we_o(result_we), .flag_s_o(fs), .flag_z_o(fz),
        .flag_c_o(fc), .flag_v_o(fv)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int fn);
        case (fn)
            0, 1:        return "R2";
            2:           return "R3";
            3:           return "R4";
            4:           return "R5";
            5, 6, 7:     return "R7";
            8, 10, 11:   return "R8";
            9:           return "R9";
            12, 13:      return "R10";
            default:     return "R12";
        endcase
    endfunction

    function automatic void model(input logic [4:0] o, input logic [15:0] x,
                                  input logic [15:0] y, input logic ci,
                                  input logic [3:0] fin, output logic [15:0] r,
                                  output logic we, output logic [3:0] fo);
        int fn  = int'(o[4:1]);
        int n   = o[0] ? 2 : 1;
        int ux  = int'(x);
        int uy  = int'(y);
        int sx  = int'($signed(x));
        int sy  = int'($signed(y));
        int t;
        logic c = fin[1];
        logic v = fin[0];
        we = 1'b1;
        r  = x;
        case (fn)
            0, 1: begin
                t = ux + uy + ((fn == 1) ? int'(ci) : 0);
                r = t[15:0];
                c = (t > 65535);
                t = sx + sy + ((fn == 1) ? int'(ci) : 0);
                v = (t > 32767) || (t < -32768);
            end
            2, 3: begin
                r  = x - y;
                c  = (ux >= uy);
                t  = sx - sy;
                v  = (t > 32767) || (t < -32768);
                we = (fn == 2);
            end
            4: begin
                r = 16'd0 - x;
                c = (x == 16'h0000);
                v = (x == 16'h8000);
            end
            5: r = ~x;
            6: r = x & y;
            7: r = x ^ y;
            8: r = 16'(ux << n);
            9: begin
                r = 16'(ux << n);
                c = x[15];
                if (n == 2) v = x[14];
            end
            10: r = 16'(ux >> n);
            11: r = 16'(sx >>> n);
            12: begin
                r = (n == 2) ? {x[13:0], ci, fin[0]} : {x[14:0], ci};
                c = x[15];
                if (n == 2) v = x[14];
            end
            13: begin
                r = (n == 2) ? {fin[0], ci, x[15:2]} : {ci, x[15:1]};
                c = x[0];
                if (n == 2) v = x[1];
            end
            default: we = 1'b0;
        endcase
        if (fn < 14) fo = {r[15], (r == 16'h0000), c, v};
        else         fo = fin;
    endfunction

    task automatic run_vec(input logic [4:0] o, input logic [15:0] x,
                           input logic [15:0] y, input logic ci, input logic w);
        logic [15:0] er;
        logic        ewe;
        logic [3:0]  ef;
        int          fn = int'(o[4:1]);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci; fwe = w;
        #1;
        model(o, x, y, ci, exp_flags, er, ewe, ef);
        check(tag_of(fn), "result_we", {31'd0, result_we}, {31'd0, ewe});
        if (ewe) check(tag_of(fn), "result", {16'd0, result}, {16'd0, er});
        if (fn == 3) begin
            logic [15:0] sr; logic swe; logic [3:0] sf;
            model({4'd2, o[0]}, x, y, ci, exp_flags, sr, swe, sf);
            ef = sf;  // R4: compare flags equal subtract flags
        end
        @(posedge clk);
        #2;
        if (w) exp_flags = ef;
        if (!w) begin
            check("R11", "flags held", {28'd0, fs, fz, fc, fv}, {28'd0, exp_flags});
        end else if (fn >= 14) begin
            check("R12", "flags held", {28'd0, fs, fz, fc, fv}, {28'd0, exp_flags});
        end else begin
            check("R6", "sign/zero", {30'd0, fs, fz}, {30'd0, exp_flags[3:2]});
            check(tag_of(fn), "carry/overflow", {30'd0, fc, fv}, {30'd0, exp_flags[1:0]});
        end
    endtask

    logic [15:0] grid [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                               16'h8001, 16'hFFFF, 16'hFFFE, 16'h5555, 16'hAAAA};

    initial begin
        rst = 1'b1; op = '0; a = '0; b = '0; cin = 1'b0; fwe = 1'b1;
        exp_flags = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "flags after reset", {28'd0, fs, fz, fc, fv}, 32'd0);

        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    for (int k = 0; k < 2; k++)
                        run_vec(5'(o), grid[i], grid[j], k[0], ($urandom % 4) != 0);

        for (int n = 0; n < 2000; n++)
            run_vec(5'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                    ($urandom % 3) != 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule